// File: doc/BRIEF.md
# Digital I/O Card Bus Register Interface

This block is the bus-facing logic of a digital I/O card with 32 inputs and 32 outputs, attached to a byte-wide legacy I/O bus with a 10-bit address. It claims an 8-byte window whose position is set by a 6-bit configuration value. The lower four offsets of the window read back the input lines and latch the output lines, one byte per offset. The upper four offsets belong to an external timer/counter: the block raises that device's chip-select and passes on the two low address bits.

All inputs are first brought into the clock domain. There are two interrupt channels. Each one selects one of four low-numbered input lines and watches it for a rising or a falling edge. A detected edge sets a sticky pending flag, which drives that channel's request output. Software clears the flag with a per-channel clear pulse, or by reading offset 0.

Bus strobes last one clock cycle and act on the rising clock edge. Read data is combinational from the synchronised inputs while the read strobe is high.

Top module: `dio_bus_if`

## Requirements
- R1: The window is hit only when bus_addr[9] is 1 and bus_addr[8:3] equals base_cfg; base_cfg = 6'b100000 places the window at 0x300..0x307.
- R2: A read strobe at a hit offset 0, 1, 2 or 3 returns iso_in[7:0], iso_in[15:8], gen_in[7:0] or gen_in[15:8] (synchronised) on bus_rdata. Any other read, and any cycle without a read, gives 8'h00.
- R3: A write strobe at hit offset k (0..3) loads bus_wdata into dout[8k+7:8k] at that clock edge and leaves the other three bytes unchanged.
- R4: A write outside the window, or at offsets 4..7, leaves dout unchanged.
- R5: While the address hits offsets 4..7, tmr_cs is 1 and tmr_a equals bus_addr[1:0]. Reads there return 8'h00. tmr_cs is 0 for any other address.
- R6: Every input passes through two flip-flops. A change shows on bus_rdata after the second clock edge, and a qualifying edge raises irq_req after the third clock edge.
- R7: The source code irq_sel[2c+1:2c] of channel c selects iso_in[0] (0), iso_in[1] (1), gen_in[0] (2) or gen_in[1] (3). Edges on unselected lines have no effect. While irq_en[c] is 0, no edge sets the channel.
- R8: irq_rise[c] = 1 selects rising edges and 0 selects falling edges. The opposite edge has no effect.
- R9: A pending flag stays set until an irq_clr[c] pulse (that channel only) or a read strobe at hit offset 0 (all channels). If a new edge arrives in the same cycle as a clear, the flag stays set.
- R10: The two channels are independent, and both requests may be high at once.
- R11: After reset, dout is all zero and every irq_req is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 10 | Bus I/O address |
| bus_rd | input | 1 | One-cycle read strobe |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data byte |
| base_cfg | input | 6 | Window base, compared with address bits 8..3 |
| iso_in | input | 16 | Isolated input lines |
| gen_in | input | 16 | Non-isolated input lines |
| dout | output | 32 | Latched output lines |
| tmr_cs | output | 1 | Timer/counter chip-select |
| tmr_a | output | 2 | Timer/counter register address |
| irq_en | input | 2 | Per-channel interrupt enable |
| irq_sel | input | 4 | Per-channel source code, 2 bits each |
| irq_rise | input | 2 | Per-channel polarity, 1 = rising |
| irq_clr | input | 2 | Per-channel pending clear pulse |
| irq_req | output | 2 | Per-channel interrupt request |

## Verification
On every cycle, the assertions check that a written byte lands in the addressed output byte. They also check that output bytes hold when no write hits, that timer offsets never put data on the read bus, and that the pending flags stay set without a clear, fall after a clear, and never rise while the channel is disabled. The bench scenarios cover the rest. These are the decode corner where the upper address bit is 0 but the base bits match, the byte order of readback, the exact latency of the synchroniser, and the choice of source and edge direction. They also cover both channels being active together, and a clear on one channel leaving the other set.

// File: rtl/dio_pkg.sv
package dio_pkg;
  localparam int WIN_LOG2 = 3;
  localparam int BYTE_W   = 8;
  localparam int GRP_W    = 16;
  localparam int PORT_BYTES = (2 * GRP_W) / BYTE_W;

  typedef enum logic [1:0] {
    SRC_ISO0 = 2'd0,
    SRC_ISO1 = 2'd1,
    SRC_GEN0 = 2'd2,
    SRC_GEN1 = 2'd3
  } irq_src_e;
endpackage

// File: rtl/dio_addr_dec.sv
module dio_addr_dec #(
  parameter int ADDR_W = 10,
  localparam int CFG_W = ADDR_W - 1 - dio_pkg::WIN_LOG2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [CFG_W-1:0]  cfg,
  output logic              port_hit,
  output logic              tmr_hit,
  output logic [1:0]        offs
);
  logic win_hit;

  always_comb begin
    win_hit  = addr[ADDR_W-1] && (addr[ADDR_W-2 -: CFG_W] == cfg);
    port_hit = win_hit && !addr[2];
    tmr_hit  = win_hit && addr[2];
    offs     = addr[1:0];
  end
endmodule

// File: rtl/dio_sync.sv
module dio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] stg_d [STAGES];

  always_comb begin
    stg_d[0] = d;
    for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
  end

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= '0;
        else        stg_q[s] <= stg_d[s];
      end
    end
  endgenerate

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/dio_irq_chan.sv
module dio_irq_chan (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] src_vec,
  input  logic [1:0] sel,
  input  logic       rise,
  input  logic       en,
  input  logic       clr,
  output logic       pending
);
  logic src, prev_q, edge_hit, pend_d;

  always_comb begin
    src      = src_vec[sel];
    edge_hit = en && (rise ? (src && !prev_q) : (!src && prev_q));
    // a fresh edge takes precedence over a clear in the same cycle
    pend_d   = edge_hit || (pending && !clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      pending <= 1'b0;
    end else begin
      prev_q  <= src;
      pending <= pend_d;
    end
  end

  // R9: flag is sticky until cleared
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    pending && !clr |=> pending);
  // R9: clear without a competing edge drops the flag
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !edge_hit |=> !pending);
  // R7: a disabled channel never raises its request
  a_r7_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !$rose(pending));
endmodule

// File: rtl/dio_bus_if.sv
module dio_bus_if #(
  parameter int ADDR_W = 10,
  parameter int N_IRQ  = 2,
  localparam int CFG_W = ADDR_W - 1 - dio_pkg::WIN_LOG2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_rd,
  input  logic                bus_wr,
  input  logic [7:0]          bus_wdata,
  output logic [7:0]          bus_rdata,
  input  logic [CFG_W-1:0]    base_cfg,
  input  logic [15:0]         iso_in,
  input  logic [15:0]         gen_in,
  output logic [31:0]         dout,
  output logic                tmr_cs,
  output logic [1:0]          tmr_a,
  input  logic [N_IRQ-1:0]    irq_en,
  input  logic [2*N_IRQ-1:0]  irq_sel,
  input  logic [N_IRQ-1:0]    irq_rise,
  input  logic [N_IRQ-1:0]    irq_clr,
  output logic [N_IRQ-1:0]    irq_req
);
  import dio_pkg::*;
  localparam int IN_W = 2 * GRP_W;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sr;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sr <= 2'b00;
    else        rst_sr <= {rst_sr[0], 1'b1};
  end
  assign rst_ni = rst_sr[1];

  logic       port_hit, tmr_hit;
  logic [1:0] offs;

  dio_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .cfg(base_cfg),
    .port_hit(port_hit), .tmr_hit(tmr_hit), .offs(offs)
  );

  logic [IN_W-1:0] in_s;
  dio_sync #(.W(IN_W), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_ni), .d({gen_in, iso_in}), .q(in_s)
  );

  // output latches
  logic [31:0] dout_q, dout_d;
  logic        wr_hit, rd0_hit;
  assign wr_hit  = bus_wr && port_hit;
  assign rd0_hit = bus_rd && port_hit && (offs == 2'd0);

  generate
    for (genvar b = 0; b < PORT_BYTES; b++) begin : g_obyte
      always_comb begin
        if (wr_hit && (offs == 2'(b))) dout_d[b*BYTE_W +: BYTE_W] = bus_wdata;
        else                           dout_d[b*BYTE_W +: BYTE_W] = dout_q[b*BYTE_W +: BYTE_W];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) dout_q <= '0;
    else         dout_q <= dout_d;
  end
  assign dout = dout_q;

  // read mux and timer pass-through
  always_comb begin
    bus_rdata = (bus_rd && port_hit) ? in_s[offs*BYTE_W +: BYTE_W] : 8'h00;
    tmr_cs    = tmr_hit;
    tmr_a     = bus_addr[1:0];
  end

  // interrupt channels
  logic [3:0] src_vec;
  assign src_vec = {in_s[GRP_W+1], in_s[GRP_W], in_s[1], in_s[0]};

  generate
    for (genvar c = 0; c < N_IRQ; c++) begin : g_irq
      dio_irq_chan u_chan (
        .clk(clk), .rst_n(rst_ni), .src_vec(src_vec),
        .sel(irq_sel[2*c +: 2]), .rise(irq_rise[c]), .en(irq_en[c]),
        .clr(irq_clr[c] || rd0_hit), .pending(irq_req[c])
      );
    end
  endgenerate

  // R3: written byte appears in the addressed lane
  a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_hit |=> dout_q[$past(offs)*BYTE_W +: BYTE_W] == $past(bus_wdata));
  // R4: no hitting write, no change on the outputs
  a_r4_miss_holds: assert property (@(posedge clk) disable iff (!rst_ni)
    !wr_hit |=> $stable(dout_q));
  // R5: timer offsets never drive read data
  a_r5_tmr_quiet: assert property (@(posedge clk) disable iff (!rst_ni)
    tmr_cs |-> bus_rdata == 8'h00);
endmodule

// File: tb/tb_dio_bus_if.sv
module tb_dio_bus_if;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [9:0]  bus_addr;
  logic        bus_rd, bus_wr;
  logic [7:0]  bus_wdata, bus_rdata;
  logic [5:0]  base_cfg;
  logic [15:0] iso_in, gen_in;
  logic [31:0] dout;
  logic        tmr_cs;
  logic [1:0]  tmr_a;
  logic [1:0]  irq_en, irq_rise, irq_clr, irq_req;
  logic [3:0]  irq_sel;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dio_bus_if dut (.*);

  // {cfg, addr, wdata, expected dout after the write}
  localparam int NV = 9;
  localparam logic [55:0] VEC [NV] = '{
    {6'h20, 10'h300, 8'hA5, 32'h000000A5},  // R3 byte 0
    {6'h20, 10'h303, 8'h3C, 32'h3C0000A5},  // R3 byte 3
    {6'h20, 10'h301, 8'hFF, 32'h3C00FFA5},  // R3 byte 1
    {6'h20, 10'h308, 8'h77, 32'h3C00FFA5},  // R4 next window
    {6'h20, 10'h102, 8'h11, 32'h3C00FFA5},  // R1 top bit clear
    {6'h20, 10'h302, 8'h5A, 32'h3C5AFFA5},  // R3 byte 2
    {6'h20, 10'h306, 8'h99, 32'h3C5AFFA5},  // R4 timer offset
    {6'h01, 10'h20B, 8'hC3, 32'hC35AFFA5},  // R1 moved window
    {6'h01, 10'h300, 8'h42, 32'hC35AFFA5}   // R1 old window gone
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bwrite(logic [9:0] a, logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic bread_chk(string req, logic [9:0] a, logic [7:0] exp);
    bus_addr = a; bus_rd = 1'b1;
    #1 chk(req, {24'h0, bus_rdata}, {24'h0, exp});
    tick();
    bus_rd = 1'b0;
  endtask

  initial begin
    #200000;
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    if (!done) begin
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_rd = 0; bus_wr = 0; bus_wdata = '0;
    base_cfg = 6'h20; iso_in = '0; gen_in = '0;
    irq_en = '0; irq_sel = '0; irq_rise = '0; irq_clr = '0;
    tick(3);
    chk("R11 dout", dout, 32'h0);
    chk("R11 irq", {30'h0, irq_req}, 32'h0);
    rst_n = 1'b1;
    tick(3);
    chk("R11 dout after release", dout, 32'h0);

    for (int i = 0; i < NV; i++) begin
      base_cfg = VEC[i][55:50];
      bwrite(VEC[i][49:40], VEC[i][39:32]);
      chk("R1/R3/R4 vector", dout, VEC[i][31:0]);
    end
    base_cfg = 6'h20;

    // R6 readback latency, R2 byte order
    iso_in = 16'h1234; gen_in = 16'hABCD;
    tick();
    bread_chk("R6 one edge old", 10'h301, 8'h00);
    bread_chk("R2 off0", 10'h300, 8'h34);
    bread_chk("R2 off1", 10'h301, 8'h12);
    bread_chk("R2 off2", 10'h302, 8'hCD);
    bread_chk("R2 off3", 10'h303, 8'hAB);
    bread_chk("R2 miss", 10'h309, 8'h00);

    // R5 timer window
    bus_addr = 10'h304; bus_rd = 1'b1;
    #1 chk("R5 cs", {31'h0, tmr_cs}, 32'h1);
    chk("R5 a", {30'h0, tmr_a}, 32'h0);
    chk("R5 rdata", {24'h0, bus_rdata}, 32'h0);
    bus_addr = 10'h307;
    #1 chk("R5 a3", {30'h0, tmr_a}, 32'h3);
    bus_addr = 10'h303;
    #1 chk("R5 cs low", {31'h0, tmr_cs}, 32'h0);
    tick(); bus_rd = 1'b0;

    // interrupts
    iso_in = '0; gen_in = '0;
    tick(4);
    irq_sel = {2'd2, 2'd1};  // ch1 gen0, ch0 iso1
    irq_rise = 2'b01;        // ch0 rising, ch1 falling
    irq_en = 2'b11;
    tick();
    iso_in[0] = 1'b1;        // unselected line
    tick(3);
    chk("R7 unselected", {30'h0, irq_req}, 32'h0);
    iso_in[1] = 1'b1;
    tick(2);
    chk("R6 irq not yet", {30'h0, irq_req}, 32'h0);
    tick();
    chk("R6 R8 rising", {30'h0, irq_req}, 32'h1);
    gen_in[0] = 1'b1;        // wrong edge for ch1
    tick(3);
    chk("R8 opposite edge", {30'h0, irq_req}, 32'h1);
    gen_in[0] = 1'b0;
    tick(3);
    chk("R10 both", {30'h0, irq_req}, 32'h3);
    irq_clr = 2'b01; tick(); irq_clr = 2'b00;
    chk("R9 clr one", {30'h0, irq_req}, 32'h2);
    tick(2);
    chk("R9 sticky", {30'h0, irq_req}, 32'h2);
    bread_chk("R9 read off0 data", 10'h300, 8'h03);
    chk("R9 read clears", {30'h0, irq_req}, 32'h0);
    irq_en = 2'b00;
    iso_in[1] = 1'b0; tick(3);
    iso_in[1] = 1'b1; tick(3);
    chk("R7 disabled", {30'h0, irq_req}, 32'h0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule